// File: doc/BRIEF.md
# Byte-Lane Data Memory

This block is the data store of a 32-bit pipelined processor. Software sees it as byte-addressed, but it keeps its contents as an array of 32-bit words. The word is chosen by the byte address shifted right by two. The two lowest address bits pick a byte or halfword inside that word. Bytes are little-endian: bit 7:0 of a stored word sits at the lowest of its four byte addresses.

The memory-access stage drives a byte address, store data, a write strobe, a read strobe, a two-bit access-size code and an unsigned-load flag. Stores take effect at the rising clock edge. A byte store or halfword store touches only the lanes it addresses. Loads are combinational from the current inputs. A byte or halfword load is sign-extended or zero-extended to 32 bits. The word count is a parameter, and any address whose word index falls beyond it is treated as unmapped. Reset clears the whole array.

Top module: `byteLaneMem`

## Requirements
- R1: With accSize 2'b10 (word), a store writes all 32 bits at word index addr>>2, and a word load returns them. addr[1:0] is ignored for word accesses, and accSize 2'b11 behaves as a word access.
- R2: Little-endian lane order. After a word store of value V, a byte load at byte offset k (k = addr[1:0]) returns V[8k+7:8k]. A halfword load at offset 2h returns V[16h+15:16h].
- R3: A byte store (accSize 2'b00) writes wrData[7:0] into lane addr[1:0] only. The other three bytes of the word keep their values.
- R4: A halfword store (accSize 2'b01) writes wrData[15:0] into bits 15:0 when addr[1]=0 and into bits 31:16 when addr[1]=1. addr[0] is ignored, and the other halfword keeps its value.
- R5: With loadUnsigned=0, byte and halfword loads copy the loaded value's top bit into all the upper bits of rdData.
- R6: With loadUnsigned=1, byte and halfword loads fill the upper bits of rdData with zeros.
- R7: While memWrite is 0, no word changes, whatever addr, wrData and accSize are.
- R8: While memRead is 0, rdData is 0.
- R9: A store becomes visible at the first rising clock edge while memWrite is 1. Before that edge, a load of the same address returns the old value.
- R10: An address whose word index addr>>2 is at or beyond WORDS is unmapped. Stores to it change no word (there is no aliasing onto low words), and loads from it return 0.
- R11: While rstN is 0, every word is cleared to 0 and stores are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores commit on its rising edge |
| rstN | input | 1 | Active-low reset; clears the array and blocks stores |
| addr | input | ADDR_W | Byte address of the access |
| wrData | input | 32 | Store data, right-aligned for byte and halfword stores |
| memWrite | input | 1 | Store strobe |
| memRead | input | 1 | Load strobe; rdData is 0 when low |
| accSize | input | 2 | Access size: 00 byte, 01 halfword, 10 or 11 word |
| loadUnsigned | input | 1 | 1 selects zero extension, 0 selects sign extension |
| rdData | output | 32 | Load result extended to 32 bits |

## Verification
The read path is combinational, so a wrong lane-enable or merge shows up on the next load of the damaged word. It is visible in the same cycle that load is driven, one edge after the faulty store. A wrong lane select or extension is visible at once on rdData, in the cycle the load is presented. A missing range gate shows only when a later load of a low word finds data that was aimed at an unmapped address, so the bench stores to word zero and then reads it back after an out-of-range store.

// File: rtl/byteLaneMemPkg.sv
package byteLaneMemPkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } accSize_t;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [LANES-1:0] laneEn;
    logic [1:0]       lane;
    accSize_t         size;
    logic             signExt;
  } memStrobe_t;

endpackage

// File: rtl/byteLaneCtrl.sv
module byteLaneCtrl
  import byteLaneMemPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 2048
) (
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              memWrite,
  input  logic              memRead,
  input  logic [1:0]        accSize,
  input  logic              loadUnsigned,
  output memStrobe_t        strobe
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0]  wordIdx;
  logic             inRange;
  accSize_t         normSize;
  logic [LANES-1:0] laneEn;

  assign wordIdx = addr[ADDR_W-1:2];
  assign inRange = (wordIdx < HI_W'(WORDS));

  always_comb begin
    case (accSize_t'(accSize))
      SZ_BYTE: normSize = SZ_BYTE;
      SZ_HALF: normSize = SZ_HALF;
      default: normSize = SZ_WORD;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_laneEn
    assign laneEn[g] = (normSize == SZ_BYTE) ? (addr[1:0] == 2'(g)) :
                       (normSize == SZ_HALF) ? (addr[1] == 1'(g / 2)) :
                                               1'b1;
  end

  always_comb begin
    strobe.wrEn    = memWrite & rstN & inRange;
    strobe.rdEn    = memRead & inRange;
    strobe.laneEn  = laneEn;
    strobe.lane    = addr[1:0];
    strobe.size    = normSize;
    strobe.signExt = ~loadUnsigned;
  end

endmodule

// File: rtl/byteLaneDatapath.sv
module byteLaneDatapath
  import byteLaneMemPkg::*;
#(
  parameter int WORDS = 2048,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [WORD_W-1:0] wrData,
  input  memStrobe_t        strobe,
  output logic [WORD_W-1:0] rdData
);

  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] curWord;
  logic [WORD_W-1:0] laneSrc;
  logic [WORD_W-1:0] mergedWord;
  logic [LANE_W-1:0] pickByte;
  logic [2*LANE_W-1:0] pickHalf;
  logic [WORD_W-1:0] loadVal;

  assign curWord = mem[wordIdx];

  always_comb begin
    case (strobe.size)
      SZ_BYTE: laneSrc = {LANES{wrData[LANE_W-1:0]}};
      SZ_HALF: laneSrc = {(LANES/2){wrData[2*LANE_W-1:0]}};
      default: laneSrc = wrData;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign mergedWord[g*LANE_W +: LANE_W] =
      strobe.laneEn[g] ? laneSrc[g*LANE_W +: LANE_W] : curWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (strobe.wrEn) begin
      mem[wordIdx] <= mergedWord;
    end
  end

  assign pickByte = curWord[{strobe.lane, 3'b000} +: LANE_W];
  assign pickHalf = curWord[{strobe.lane[1], 4'b0000} +: 2*LANE_W];

  always_comb begin
    case (strobe.size)
      SZ_BYTE: loadVal = {{(WORD_W-LANE_W){strobe.signExt & pickByte[LANE_W-1]}}, pickByte};
      SZ_HALF: loadVal = {{(WORD_W-2*LANE_W){strobe.signExt & pickHalf[2*LANE_W-1]}}, pickHalf};
      default: loadVal = curWord;
    endcase
  end

  assign rdData = strobe.rdEn ? loadVal : '0;

endmodule

// File: rtl/byteLaneMem.sv
module byteLaneMem
  import byteLaneMemPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              memWrite,
  input  logic              memRead,
  input  logic [1:0]        accSize,
  input  logic              loadUnsigned,
  output logic [31:0]       rdData
);

  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  memStrobe_t strobe;

  byteLaneCtrl #(.ADDR_W(ADDR_W), .WORDS(WORDS)) i_ctrl (
    .rstN         (rstN),
    .addr         (addr),
    .memWrite     (memWrite),
    .memRead      (memRead),
    .accSize      (accSize),
    .loadUnsigned (loadUnsigned),
    .strobe       (strobe)
  );

  byteLaneDatapath #(.WORDS(WORDS)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .wordIdx (addr[IDX_W+1:2]),
    .wrData  (wrData),
    .strobe  (strobe),
    .rdData  (rdData)
  );

endmodule

// File: rtl/byteLaneMemChk.sv
module byteLaneMemChk #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 2048
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic              memWrite,
  input logic              memRead,
  input logic [1:0]        accSize,
  input logic              loadUnsigned,
  input logic [31:0]       rdData
);

  logic mapped;
  assign mapped = (addr[ADDR_W-1:2] < (ADDR_W-2)'(WORDS));

  p_signed_byte_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memRead && mapped && accSize == 2'b00 && !loadUnsigned) |-> (rdData[31:8] == {24{rdData[7]}}));

  p_signed_half_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memRead && mapped && accSize == 2'b01 && !loadUnsigned) |-> (rdData[31:16] == {16{rdData[15]}}));

  p_unsigned_byte_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memRead && accSize == 2'b00 && loadUnsigned) |-> (rdData[31:8] == 24'h0));

  p_unsigned_half_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memRead && accSize == 2'b01 && loadUnsigned) |-> (rdData[31:16] == 16'h0));

  p_no_write_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(memWrite) && $past(memRead) && memRead &&
     $stable(addr) && $stable(accSize) && $stable(loadUnsigned)) |-> $stable(rdData));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !memRead |-> (rdData == 32'h0));

  p_write_visible_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(memWrite) && $past(accSize) == 2'b10 &&
     memRead && accSize == 2'b10 && mapped && $stable(addr)) |-> (rdData == $past(wrData)));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memRead && !mapped) |-> (rdData == 32'h0));

endmodule

bind byteLaneMem byteLaneMemChk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .addr         (addr),
  .wrData       (wrData),
  .memWrite     (memWrite),
  .memRead      (memRead),
  .accSize      (accSize),
  .loadUnsigned (loadUnsigned),
  .rdData       (rdData)
);

// File: tb/test_byteLaneMem.sv
module test_byteLaneMem;

  localparam int WORDS = 2048;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] addr;
  logic [31:0] wrData;
  logic        memWrite;
  logic        memRead;
  logic [1:0]  accSize;
  logic        loadUnsigned;
  logic [31:0] rdData;

  always #10 clk = ~clk;

  byteLaneMem #(.ADDR_W(32), .WORDS(WORDS)) i_byteLaneMem (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .memWrite(memWrite),
    .memRead(memRead), .accSize(accSize), .loadUnsigned(loadUnsigned), .rdData(rdData)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0]  mdl [int unsigned];
  logic [31:0] expQ [$];
  string       tagQ [$];
  event        sampleEv;

  function automatic logic [7:0] mb(int unsigned a);
    return mdl.exists(a) ? mdl[a] : 8'h00;
  endfunction

  function automatic bit mappedAddr(logic [31:0] a);
    return (a >> 2) < WORDS;
  endfunction

  function automatic logic [31:0] expLoad(logic [31:0] a, logic [1:0] sz, logic uns);
    logic [31:0] b;
    logic [7:0]  v8;
    logic [15:0] v16;
    if (!mappedAddr(a)) return 32'h0;
    case (sz)
      2'b00: begin
        v8 = mb(a);
        return uns ? {24'h0, v8} : {{24{v8[7]}}, v8};
      end
      2'b01: begin
        b = a & ~32'h1;
        v16 = {mb(b + 1), mb(b)};
        return uns ? {16'h0, v16} : {{16{v16[15]}}, v16};
      end
      default: begin
        b = a & ~32'h3;
        return {mb(b + 3), mb(b + 2), mb(b + 1), mb(b)};
      end
    endcase
  endfunction

  task automatic modelStore(logic [31:0] a, logic [31:0] d, logic [1:0] sz);
    logic [31:0] b;
    if (!mappedAddr(a)) return;
    case (sz)
      2'b00: mdl[a] = d[7:0];
      2'b01: begin
        b = a & ~32'h1;
        mdl[b] = d[7:0]; mdl[b + 1] = d[15:8];
      end
      default: begin
        b = a & ~32'h3;
        mdl[b] = d[7:0]; mdl[b + 1] = d[15:8]; mdl[b + 2] = d[23:16]; mdl[b + 3] = d[31:24];
      end
    endcase
  endtask

  task automatic expect32(logic [31:0] v, string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
    -> sampleEv;
  endtask

  task automatic doLoad(logic [31:0] a, logic [1:0] sz, logic uns, string tag);
    @(negedge clk);
    memWrite = 1'b0; memRead = 1'b1; addr = a; accSize = sz; loadUnsigned = uns;
    expect32(expLoad(a, sz, uns), tag);
  endtask

  task automatic doStore(logic [31:0] a, logic [31:0] d, logic [1:0] sz);
    @(negedge clk);
    memWrite = 1'b1; memRead = 1'b0; addr = a; wrData = d; accSize = sz;
    @(posedge clk);
    if (rstN) modelStore(a, d, sz);
    #1 memWrite = 1'b0;
  endtask

  // monitor: pops one expected item per driven load, samples mid low phase
  initial begin
    forever begin
      logic [31:0] e;
      string t;
      @(sampleEv);
      #5;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (rdData !== e) begin
        fails++;
        $display("FAIL %s got=%h exp=%h", t, rdData, e);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; addr = '0; wrData = '0; memWrite = 1'b0; memRead = 1'b0;
    accSize = 2'b10; loadUnsigned = 1'b0;
    // R11: a store attempted during reset is dropped
    doStore(32'h8, 32'h1234_5678, 2'b10);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doLoad(32'h8, 2'b10, 1'b0, "R11 store under reset ignored");
    doLoad(32'h0, 2'b10, 1'b0, "R11 reset state zero");

    // R1 word round trip, low bits ignored, code 11 as word
    doStore(32'h100, 32'hDEAD_BEEF, 2'b10);
    doLoad(32'h100, 2'b10, 1'b0, "R1 word load");
    doLoad(32'h103, 2'b10, 1'b0, "R1 word low bits ignored");
    doLoad(32'h101, 2'b11, 1'b0, "R1 size 11 as word");

    // R2 little-endian lanes
    doLoad(32'h100, 2'b00, 1'b1, "R2 lane0 byte");
    doLoad(32'h101, 2'b00, 1'b1, "R2 lane1 byte");
    doLoad(32'h102, 2'b00, 1'b1, "R2 lane2 byte");
    doLoad(32'h103, 2'b00, 1'b1, "R2 lane3 byte");
    doLoad(32'h102, 2'b01, 1'b1, "R2 upper half");

    // R3 byte store touches one lane
    doStore(32'h101, 32'h0000_005A, 2'b00);
    doLoad(32'h100, 2'b10, 1'b0, "R3 byte lane1 merge");
    doStore(32'h103, 32'hFFFF_FF12, 2'b00);
    doLoad(32'h100, 2'b10, 1'b0, "R3 byte lane3 merge");

    // R4 halfword store lane pair by addr[1], addr[0] ignored
    doStore(32'h200, 32'h1122_3344, 2'b10);
    doStore(32'h203, 32'h5555_ABCD, 2'b01);
    doLoad(32'h200, 2'b10, 1'b0, "R4 upper half store");
    doStore(32'h200, 32'h0000_9876, 2'b01);
    doLoad(32'h200, 2'b10, 1'b0, "R4 lower half store");

    // R5 sign extension
    doLoad(32'h200, 2'b00, 1'b0, "R5 signed byte positive");
    doLoad(32'h201, 2'b00, 1'b0, "R5 signed byte negative");
    doLoad(32'h202, 2'b01, 1'b0, "R5 signed half negative");
    doLoad(32'h200, 2'b01, 1'b0, "R5 signed half 9876");

    // R6 zero extension
    doLoad(32'h201, 2'b00, 1'b1, "R6 unsigned byte");
    doLoad(32'h202, 2'b01, 1'b1, "R6 unsigned half");

    // R7 memWrite low with live data
    @(negedge clk);
    memWrite = 1'b0; memRead = 1'b0; addr = 32'h200; wrData = 32'hFFFF_FFFF; accSize = 2'b10;
    @(negedge clk);
    doLoad(32'h200, 2'b10, 1'b0, "R7 no write when strobe low");

    // R8 read strobe low
    @(negedge clk);
    memRead = 1'b0; addr = 32'h100; accSize = 2'b10;
    expect32(32'h0, "R8 idle read zero");

    // R9 old value before edge, new after
    @(negedge clk);
    memWrite = 1'b1; memRead = 1'b1; addr = 32'h300; wrData = 32'hCAFE_F00D; accSize = 2'b10;
    loadUnsigned = 1'b0;
    expect32(expLoad(32'h300, 2'b10, 1'b0), "R9 old value before edge");
    @(posedge clk);
    modelStore(32'h300, 32'hCAFE_F00D, 2'b10);
    #1 memWrite = 1'b0;
    doLoad(32'h300, 2'b10, 1'b0, "R9 new value after edge");

    // R10 unmapped addresses, no aliasing onto word 0
    doStore(32'h0, 32'h0102_0304, 2'b10);
    doStore(32'h2000, 32'hFFFF_FFFF, 2'b10);
    doStore(32'hFFFF_FFF0, 32'hAAAA_AAAA, 2'b10);
    doLoad(32'h0, 2'b10, 1'b0, "R10 no alias on word 0");
    doLoad(32'h2000, 2'b10, 1'b0, "R10 unmapped load zero");
    doLoad(32'h2001, 2'b00, 1'b0, "R10 unmapped byte zero");
    doLoad(32'h1FFC, 2'b10, 1'b0, "R10 last mapped word");

    // R11 reset in mid-run clears words
    @(negedge clk);
    memRead = 1'b0;
    rstN = 1'b0;
    mdl.delete();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    doLoad(32'h100, 2'b10, 1'b0, "R11 clear after reset");
    doLoad(32'h300, 2'b10, 1'b0, "R11 clear after reset second word");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule